// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel ports, A and B, in both directions. Each direction has a storage register with its own capture strobe. Each direction also has a select that decides what the far port is driven with: the live value of the near port, or the contents of that direction's register. Two enables decide whether each port drives: the B-side enable is active high and the A-side enable is active low. Each bidirectional pin is split into an input bus, an output bus and a per-bit output-enable vector. The surrounding fabric or the testbench resolves them into wires.

A register always captures its port's *resolved* value. For a port that is not driven, that is the external input. For a port that is driven, it is the block's own output. This is how the block loads a port's data into both registers, or swaps the stored words between the ports in one configuration. Both strobes are sampled on the rising edge of one system clock. A synchronous reset clears both registers.

The two enables are decoded each cycle into a drive mode with four named states:
- `MODE_ISOLATE`: no port drives.
- `MODE_DRIVE_A`: only A drives.
- `MODE_DRIVE_B`: only B drives.
- `MODE_DRIVE_BOTH`: both ports drive.

The mode moves directly between any two states whenever the enables change; there is no sequencing. One process holds the captured words. A second process derives the drive controls from the mode.

Top module: `regbus_xcvr`

## Requirements
- R1: When `cap_ab_stb` is high at a rising clock edge (and `rst` is low), the A-to-B register loads the resolved A value, whatever the enables are. Otherwise it holds.
- R2: When `cap_ba_stb` is high at a rising clock edge (and `rst` is low), the B-to-A register loads the resolved B value, whatever the enables are. Otherwise it holds.
- R3: A rising edge with `rst` high clears both registers to zero. After reset, every stored-data output reads 0.
- R4: B drives exactly when `en_b` is 1; then all bits of `b_oe` are 1. Otherwise `b_oe` and `b_out` are all zero.
- R5: A drives exactly when `en_a_n` is 0; then all bits of `a_oe` are 1. Otherwise `a_oe` and `a_out` are all zero.
- R6: While B drives, `sel_ab` = 0 puts the live A value on `b_out`, and `sel_ab` = 1 puts the A-to-B register on `b_out`. The live A value is `a_in` when A does not drive, or the stored B-to-A word when A drives from storage.
- R7: While A drives, `sel_ba` = 0 puts the live B value on `a_out`, and `sel_ba` = 1 puts the B-to-A register on `a_out`. The live B value is `b_in` when B does not drive, or the stored A-to-B word when B drives from storage.
- R8: With both ports driving and both selects at 1, `b_out` shows the A-to-B register and `a_out` shows the B-to-A register in the same cycle.
- R9: With B driving live A data (`en_b`=1, `sel_ab`=0, A not driving), a `cap_ba_stb` pulse stores the `a_in` value in the B-to-A register.
- R10: With A driving live B data (`en_a_n`=0, `sel_ba`=0, B not driving), a `cap_ab_stb` pulse stores the `b_in` value in the A-to-B register.
- R11: When both strobes are high on the same edge, each register takes the resolved value present before that edge. With B driving from storage, the B-to-A register therefore receives the old A-to-B word.
- R12: With both ports driving and both selects at 0, `b_out` equals `a_in` and `a_out` equals `b_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cap_ab_stb | input | 1 | Capture strobe of the A-to-B register |
| cap_ba_stb | input | 1 | Capture strobe of the B-to-A register |
| sel_ab | input | 1 | B source: 0 live A, 1 stored A-to-B word |
| sel_ba | input | 1 | A source: 0 live B, 1 stored B-to-A word |
| en_b | input | 1 | B-side drive enable, active high |
| en_a_n | input | 1 | A-side drive enable, active low |
| a_in | input | W | External value on the A pins |
| a_out | output | W | Value the block drives onto A |
| a_oe | output | W | Per-bit drive enable for A |
| b_in | input | W | External value on the B pins |
| b_out | output | W | Value the block drives onto B |
| b_oe | output | W | Per-bit drive enable for B |

## Verification
Assertions check the following on every cycle:
- Each register's capture-or-hold behaviour and its clearing by reset.
- Zero outputs and zero enables on a port that is not driven.
- The exchange configuration, where both stored words cross at once.
- The crossed live case, where both ports drive live data.

Some behaviours depend on what a register held several cycles earlier, so only the bench's scenarios can show them:
- Loading one port's word into both registers through the live path.
- The same-edge capture, where a register sees the other register's old contents.
- Whether the stored words that reappear after reset and after random traffic are correct.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Drive mode decoded from the two port enables: {B drives, A drives}
    typedef enum logic [1:0] {
        MODE_ISOLATE    = 2'b00,
        MODE_DRIVE_A    = 2'b01,
        MODE_DRIVE_B    = 2'b10,
        MODE_DRIVE_BOTH = 2'b11
    } xcvr_mode_e;

    function automatic xcvr_mode_e decode_mode(input logic en_b, input logic en_a_n);
        return xcvr_mode_e'({en_b, ~en_a_n});
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R3: reset empties the register
    assert_reset_clear_R3: assert property (@(posedge clk) rst |=> q == '0);

    // R1 / R2: a strobe loads the resolved port value
    assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d));

    // R1 / R2: without a strobe the word is held
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route #(
    parameter int W = 8
) (
    input  logic         drive,
    input  logic         sel_stored,
    input  logic [W-1:0] stored,
    input  logic [W-1:0] live,
    output logic [W-1:0] out,
    output logic [W-1:0] oe
);

    logic [W-1:0] chosen;

    always_comb begin
        chosen = sel_stored ? stored : live;
        out    = drive ? chosen : '0;
        oe     = {W{drive}};
    end

    // R4 / R5: idle port neither drives nor shows data
    always_comb begin
        assert_idle_quiet_R4: assert (drive || (out == '0 && oe == '0));
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_ab_stb,
    input  logic         cap_ba_stb,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         en_b,
    input  logic         en_a_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    xcvr_mode_e   mode;
    logic         drive_a, drive_b;
    logic [W-1:0] q_ab, q_ba;
    logic [W-1:0] a_ext, b_ext;
    logic [W-1:0] a_pin, b_pin;
    logic [W-1:0] a_drv, b_drv;

    // Output process: drive controls from the decoded mode
    always_comb begin
        mode = decode_mode(en_b, en_a_n);
        unique case (mode)
            MODE_ISOLATE:    begin drive_a = 1'b0; drive_b = 1'b0; end
            MODE_DRIVE_A:    begin drive_a = 1'b1; drive_b = 1'b0; end
            MODE_DRIVE_B:    begin drive_a = 1'b0; drive_b = 1'b1; end
            MODE_DRIVE_BOTH: begin drive_a = 1'b1; drive_b = 1'b1; end
            default:         begin drive_a = 1'b0; drive_b = 1'b0; end
        endcase
    end

    // Port values excluding any live path (breaks the A<->B loop)
    always_comb begin
        a_ext = (drive_a && sel_ba) ? q_ba : a_in;
        b_ext = (drive_b && sel_ab) ? q_ab : b_in;
    end

    xcvr_route #(.W(W)) u_route_b (
        .drive(drive_b), .sel_stored(sel_ab), .stored(q_ab), .live(a_ext),
        .out(b_drv), .oe(b_oe)
    );

    xcvr_route #(.W(W)) u_route_a (
        .drive(drive_a), .sel_stored(sel_ba), .stored(q_ba), .live(b_ext),
        .out(a_drv), .oe(a_oe)
    );

    // Resolved pin values seen by the registers
    always_comb begin
        a_pin = drive_a ? a_drv : a_in;
        b_pin = drive_b ? b_drv : b_in;
        a_out = a_drv;
        b_out = b_drv;
    end

    // State process: the two captured words
    xcvr_store #(.W(W)) u_store_ab (
        .clk(clk), .rst(rst), .load(cap_ab_stb), .d(a_pin), .q(q_ab)
    );

    xcvr_store #(.W(W)) u_store_ba (
        .clk(clk), .rst(rst), .load(cap_ba_stb), .d(b_pin), .q(q_ba)
    );

    assert_b_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !en_b |-> (b_oe == '0 && b_out == '0));

    assert_a_idle_R5: assert property (@(posedge clk) disable iff (rst)
        en_a_n |-> (a_oe == '0 && a_out == '0));

    assert_exchange_R8: assert property (@(posedge clk) disable iff (rst)
        (en_b && !en_a_n && sel_ab && sel_ba) |-> (b_out == q_ab && a_out == q_ba));

    assert_cross_live_R12: assert property (@(posedge clk) disable iff (rst)
        (en_b && !en_a_n && !sel_ab && !sel_ba) |-> (b_out == a_in && a_out == b_in));

    // R9: B driving live A, a B-to-A strobe stores a_in
    assert_mirror_a_R9: assert property (@(posedge clk) disable iff (rst)
        (en_b && en_a_n && !sel_ab && cap_ba_stb) |=> q_ba == $past(a_in));

endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
    localparam int W = 8;
    localparam time PERIOD = 10ns;

    logic clk = 0;
    logic rst, cap_ab_stb, cap_ba_stb, sel_ab, sel_ba, en_b, en_a_n;
    logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

    regbus_xcvr #(.W(W)) u_dut (.*);

    always #(PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;
    string force_tag = "";

    function automatic logic [W-1:0] exp_b(input logic [W-1:0] ab, input logic [W-1:0] ba);
        logic [W-1:0] a_live;
        if (!en_b) return '0;
        if (sel_ab) return ab;
        a_live = (!en_a_n && sel_ba) ? ba : a_in;
        return a_live;
    endfunction

    function automatic logic [W-1:0] exp_a(input logic [W-1:0] ab, input logic [W-1:0] ba);
        logic [W-1:0] b_live;
        if (en_a_n) return '0;
        if (sel_ba) return ba;
        b_live = (en_b && sel_ab) ? ab : b_in;
        return b_live;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic cab, input logic cba, input logic sab,
                        input logic sba, input logic eb, input logic ean,
                        input logic [W-1:0] av, input logic [W-1:0] bv);
        logic [W-1:0] eb_v, ea_v, pa, pb;
        string tb_tag, ta_tag;
        @(negedge clk);
        rst = r; cap_ab_stb = cab; cap_ba_stb = cba; sel_ab = sab; sel_ba = sba;
        en_b = eb; en_a_n = ean; a_in = av; b_in = bv;
        #1;
        eb_v = exp_b(m_ab, m_ba);
        ea_v = exp_a(m_ab, m_ba);
        if (!r) begin
            tb_tag = "R6"; ta_tag = "R7";
            if (eb && !ean && sab && sba) begin tb_tag = "R8"; ta_tag = "R8"; end
            if (eb && !ean && !sab && !sba) begin tb_tag = "R12"; ta_tag = "R12"; end
            if (force_tag != "") begin tb_tag = force_tag; ta_tag = force_tag; end
            check(tb_tag, b_out, eb_v);
            check(ta_tag, a_out, ea_v);
            check("R4", b_oe, {W{eb}});
            check("R5", a_oe, {W{~ean}});
        end
        pa = ean ? av : ea_v;
        pb = eb ? eb_v : bv;
        @(posedge clk);
        if (r) begin m_ab = '0; m_ba = '0; end
        else begin
            if (cab) m_ab = pa;
            if (cba) m_ba = pb;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        step(1, 1, 1, 0, 0, 0, 1, 8'hFF, 8'hFF);
        step(1, 0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
        // R3: stored words read zero after reset
        force_tag = "R3";
        step(0, 0, 0, 1, 1, 1, 0, 8'hA5, 8'h5A);
        force_tag = "";
        // R1 / R2: capture with ports isolated, read back via exchange (R8)
        step(0, 1, 1, 0, 0, 0, 1, 8'h3C, 8'hC3);
        force_tag = "R1";
        step(0, 0, 0, 1, 1, 1, 0, 8'h00, 8'h00);
        force_tag = "R2";
        step(0, 0, 0, 1, 1, 1, 0, 8'h11, 8'h22);
        force_tag = "";
        // R9: B driven with live A, B-to-A strobe stores a_in
        step(0, 0, 1, 0, 0, 1, 1, 8'h96, 8'h00);
        force_tag = "R9";
        step(0, 0, 0, 0, 1, 0, 0, 8'h00, 8'h77);
        force_tag = "";
        // R10: A driven with live B, A-to-B strobe stores b_in
        step(0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h4B);
        force_tag = "R10";
        step(0, 0, 0, 1, 0, 1, 1, 8'h99, 8'h00);
        force_tag = "";
        // R11: same-edge strobes with B from storage; B-to-A gets old A-to-B word
        step(0, 1, 1, 1, 0, 1, 1, 8'hE1, 8'h00);
        force_tag = "R11";
        step(0, 0, 0, 1, 1, 1, 0, 8'h00, 8'h00);
        force_tag = "";
        // R12: both ports live
        step(0, 0, 0, 0, 0, 1, 0, 8'h12, 8'h34);
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 50) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom % 2, $urandom % 2, W'($urandom), W'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule